// File: doc/BRIEF.md
# Dual-Thread Core Idle-State Resolver

This block follows the idle-state requests of the two hardware threads that share one processor core. It merges them into one resolved core idle level. Each thread moves between an active state and four idle depths. The core reports the shallowest depth that both threads allow. Wake sources pull threads back to the active state: per-thread interrupts, a package-wide wake, and a hit on a watched memory address. Whether one thread or both threads wake depends on how deep the core is.

Every thread runs the same small state machine. Its states are C0 (active), C1 (halt), C1E (enhanced halt), C3 (sleep) and C6 (deep power-down). The transitions are:
- request-accept: C0 to the requested idle state.
- wake: any idle state back to C0.
- hold: remain in the current state.

The deepest level needs both threads. A thread that asks for C6 while its partner has not is shown at C3 until the partner also asks for C6. A registered merge stage then forms the core level from the two thread levels.

Top module: `cstate_resolver`

## Requirements
- R1: States are coded on 3 bits as C0=0, C1=1, C1E=2, C3=3, C6=4. When a thread is in C0, a valid request with code 1, 2, 3 or 4 is adopted, and the new state is visible on that thread's state port after one clock edge.
- R2: The core state port shows the numerically lowest of the two thread state ports, one clock cycle after them.
- R3: A request to a thread that is not in C0 is ignored, and its state stays unchanged.
- R4: A request with code 0, 5, 6 or 7 is ignored.
- R5: An interrupt to one thread while that thread is in C1, C1E or C3 returns only that thread to C0, and the other thread keeps its state.
- R6: When both threads are in C6, an interrupt to either thread returns both threads to C0.
- R7: A thread that has requested C6 reports C3 while its partner has not requested C6. Both report C6 once both have requested it, including when both requests arrive in the same cycle.
- R8: A watched-address hit returns to C0 every idle thread whose request carried the wait flag, and leaves threads that requested without the flag unchanged.
- R9: A package wake returns both threads to C0.
- R10: A wake aimed at a thread in C0 takes precedence over a same-cycle request, so the thread stays in C0.
- R11: During and after reset, both thread states and the core state are C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t0_req_vld | input | 1 | Thread 0 idle request strobe |
| t0_req_state | input | 3 | Thread 0 requested state code |
| t0_req_wait | input | 1 | Thread 0 request entered by wait-on-address |
| t1_req_vld | input | 1 | Thread 1 idle request strobe |
| t1_req_state | input | 3 | Thread 1 requested state code |
| t1_req_wait | input | 1 | Thread 1 request entered by wait-on-address |
| irq | input | 2 | Per-thread interrupt, bit n targets thread n |
| pkg_wake | input | 1 | Package-level wake for both threads |
| mon_hit | input | 1 | Watched address was accessed |
| t0_state | output | 3 | Thread 0 current state |
| t1_state | output | 3 | Thread 1 current state |
| core_state | output | 3 | Resolved core state |

## Verification
The assertions take each input as a single-cycle level that is sampled at the rising edge. They also assume the request code is meaningful only when the strobe is high. They assume nothing about ordering, so wakes and requests may coincide freely. The stimulus changes inputs only on the falling edge and clears them after one cycle. It deliberately combines a wake with a request, and a request to a busy thread, so that the priority rules are exercised without relying on any ordering assumption.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        CS_C0  = 3'd0,
        CS_C1  = 3'd1,
        CS_C1E = 3'd2,
        CS_C3  = 3'd3,
        CS_C6  = 3'd4
    } cstate_e;

    localparam logic [STATE_W-1:0] CODE_MIN = 3'd1;
    localparam logic [STATE_W-1:0] CODE_MAX = 3'd4;
endpackage

// File: rtl/cstate_thread.sv
module cstate_thread
    import cstate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [STATE_W-1:0] req_state,
    input  logic               req_wait,
    input  logic               irq_own,
    input  logic               wake_all,
    input  logic               mon_hit,
    input  logic               peer_c6,
    output logic               tgt_c6,
    output cstate_e            state_o
);
    cstate_e tgt_q, tgt_d;
    logic    wait_q, wait_d;
    logic    wake;
    logic    req_ok;

    assign wake   = irq_own | wake_all | (mon_hit & wait_q);
    assign req_ok = req_vld && (req_state >= CODE_MIN) && (req_state <= CODE_MAX);

    // next-state
    always_comb begin
        tgt_d  = tgt_q;
        wait_d = wait_q;
        unique case (tgt_q)
            CS_C0: begin
                if (!wake && req_ok) begin
                    tgt_d  = cstate_e'(req_state);
                    wait_d = req_wait;
                end
            end
            CS_C1, CS_C1E, CS_C3, CS_C6: begin
                if (wake) begin
                    tgt_d  = CS_C0;
                    wait_d = 1'b0;
                end
            end
            default: begin
                tgt_d  = CS_C0;
                wait_d = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= CS_C0;
            wait_q <= 1'b0;
        end else begin
            tgt_q  <= tgt_d;
            wait_q <= wait_d;
        end
    end

    // outputs
    always_comb begin
        tgt_c6 = 1'b0;
        unique case (tgt_q)
            CS_C6: begin
                tgt_c6  = 1'b1;
                state_o = peer_c6 ? CS_C6 : CS_C3;
            end
            default: state_o = tgt_q;
        endcase
    end

    AST_WAKE_TO_C0: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_own || wake_all) |=> (tgt_q == CS_C0)); // R5

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q != CS_C0 && !wake) |=> $stable(tgt_q)); // R3

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == CS_C0 && req_vld && (req_state == 3'd0 || req_state > CODE_MAX))
        |=> (tgt_q == CS_C0)); // R4

    AST_WAKE_BEATS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == CS_C0 && wake) |=> (tgt_q == CS_C0)); // R10
endmodule

// File: rtl/cstate_merge.sv
module cstate_merge
    import cstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cstate_e st_a,
    input  cstate_e st_b,
    output cstate_e core_q
);
    cstate_e lowest;

    always_comb begin
        lowest = (st_a <= st_b) ? st_a : st_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= CS_C0;
        else        core_q <= lowest;
    end

    AST_CORE_NOT_DEEPER_A: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_q <= $past(st_a))); // R2

    AST_CORE_NOT_DEEPER_B: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_q <= $past(st_b))); // R2

    AST_CORE_MATCHES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_q == $past(st_a) || core_q == $past(st_b))); // R2
endmodule

// File: rtl/cstate_resolver.sv
module cstate_resolver
    import cstate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               t0_req_vld,
    input  logic [STATE_W-1:0] t0_req_state,
    input  logic               t0_req_wait,
    input  logic               t1_req_vld,
    input  logic [STATE_W-1:0] t1_req_state,
    input  logic               t1_req_wait,
    input  logic [1:0]         irq,
    input  logic               pkg_wake,
    input  logic               mon_hit,
    output logic [STATE_W-1:0] t0_state,
    output logic [STATE_W-1:0] t1_state,
    output logic [STATE_W-1:0] core_state
);
    localparam int NTHR = 2;

    logic               vld_a  [NTHR];
    logic [STATE_W-1:0] code_a [NTHR];
    logic               wait_a [NTHR];
    logic [NTHR-1:0]    tgt_c6;
    logic               both_c6;
    cstate_e            st [NTHR];
    cstate_e            core_q;

    assign vld_a[0]  = t0_req_vld;
    assign vld_a[1]  = t1_req_vld;
    assign code_a[0] = t0_req_state;
    assign code_a[1] = t1_req_state;
    assign wait_a[0] = t0_req_wait;
    assign wait_a[1] = t1_req_wait;
    assign both_c6   = &tgt_c6;

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        logic wake_all;
        assign wake_all = pkg_wake | (both_c6 & irq[NTHR-1-g]);

        cstate_thread u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_vld  (vld_a[g]),
            .req_state(code_a[g]),
            .req_wait (wait_a[g]),
            .irq_own  (irq[g]),
            .wake_all (wake_all),
            .mon_hit  (mon_hit),
            .peer_c6  (tgt_c6[NTHR-1-g]),
            .tgt_c6   (tgt_c6[g]),
            .state_o  (st[g])
        );
    end

    cstate_merge u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .st_a  (st[0]),
        .st_b  (st[1]),
        .core_q(core_q)
    );

    assign t0_state   = st[0];
    assign t1_state   = st[1];
    assign core_state = core_q;

    AST_C6_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] == CS_C6) == (st[1] == CS_C6)); // R7

    AST_C6_IRQ_WAKES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] == CS_C6 && irq != 2'b00) |=> (st[0] == CS_C0 && st[1] == CS_C0)); // R6

    AST_PKG_WAKE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_wake |=> (st[0] == CS_C0 && st[1] == CS_C0)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (st[0] == CS_C0 && st[1] == CS_C0 && core_q == CS_C0)); // R11
endmodule

// File: tb/cstate_resolver_test.sv
`timescale 1ns/1ps
module cstate_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t0_req_vld = 0, t0_req_wait = 0, t1_req_vld = 0, t1_req_wait = 0;
    logic [2:0] t0_req_state = 0, t1_req_state = 0;
    logic [1:0] irq = 0;
    logic       pkg_wake = 0, mon_hit = 0;
    logic [2:0] t0_state, t1_state, core_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cstate_resolver uut (
        .clk(clk), .rst_n(rst_n),
        .t0_req_vld(t0_req_vld), .t0_req_state(t0_req_state), .t0_req_wait(t0_req_wait),
        .t1_req_vld(t1_req_vld), .t1_req_state(t1_req_state), .t1_req_wait(t1_req_wait),
        .irq(irq), .pkg_wake(pkg_wake), .mon_hit(mon_hit),
        .t0_state(t0_state), .t1_state(t1_state), .core_state(core_state)
    );

    typedef struct packed {
        logic       v0; logic [2:0] s0; logic w0;
        logic       v1; logic [2:0] s1; logic w1;
        logic [1:0] ir; logic pk; logic mh;
        logic [2:0] e0; logic [2:0] e1;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1,3'd1,0, 0,3'd0,0, 2'b00,0,0, 3'd1,3'd0, 4'd1},  // R1 t0 -> C1
        '{0,3'd0,0, 1,3'd3,0, 2'b00,0,0, 3'd1,3'd3, 4'd1},  // R1 t1 -> C3
        '{0,3'd0,0, 0,3'd0,0, 2'b01,0,0, 3'd0,3'd3, 4'd5},  // R5 irq t0 only
        '{1,3'd2,1, 0,3'd0,0, 2'b00,0,0, 3'd2,3'd3, 4'd1},  // R1 t0 -> C1E with wait
        '{0,3'd0,0, 0,3'd0,0, 2'b00,0,1, 3'd0,3'd3, 4'd8},  // R8 hit wakes t0 only
        '{1,3'd4,0, 0,3'd0,0, 2'b00,0,0, 3'd3,3'd3, 4'd7},  // R7 held at C3
        '{0,3'd0,0, 1,3'd4,0, 2'b00,0,0, 3'd3,3'd3, 4'd3},  // R3 t1 busy, ignored
        '{0,3'd0,0, 0,3'd0,0, 2'b10,0,0, 3'd3,3'd0, 4'd5},  // R5 irq t1 only
        '{0,3'd0,0, 1,3'd4,0, 2'b00,0,0, 3'd4,3'd4, 4'd7},  // R7 both C6
        '{0,3'd0,0, 0,3'd0,0, 2'b00,0,0, 3'd4,3'd4, 4'd2},  // R2 core reaches C6
        '{0,3'd0,0, 0,3'd0,0, 2'b10,0,0, 3'd0,3'd0, 4'd6},  // R6 irq wakes both
        '{1,3'd5,0, 1,3'd7,0, 2'b00,0,0, 3'd0,3'd0, 4'd4},  // R4 bad codes
        '{1,3'd0,0, 0,3'd0,0, 2'b00,0,0, 3'd0,3'd0, 4'd4},  // R4 code 0
        '{1,3'd3,0, 0,3'd0,0, 2'b01,0,0, 3'd0,3'd0, 4'd10}, // R10 wake beats req
        '{1,3'd1,0, 1,3'd2,1, 2'b00,0,0, 3'd1,3'd2, 4'd1},  // R1 both idle
        '{0,3'd0,0, 0,3'd0,0, 2'b00,1,0, 3'd0,3'd0, 4'd9},  // R9 package wake
        '{1,3'd4,0, 1,3'd4,0, 2'b00,0,0, 3'd4,3'd4, 4'd7},  // R7 same-cycle C6
        '{0,3'd0,0, 0,3'd0,0, 2'b01,0,0, 3'd0,3'd0, 4'd6},  // R6 irq t0 wakes both
        '{1,3'd3,1, 1,3'd3,1, 2'b00,0,0, 3'd3,3'd3, 4'd1},  // R1 both C3 with wait
        '{0,3'd0,0, 0,3'd0,0, 2'b00,0,1, 3'd0,3'd0, 4'd8}   // R8 hit wakes both
    };

    task automatic check(input int rq, input string what, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_in();
        t0_req_vld = 0; t0_req_state = 0; t0_req_wait = 0;
        t1_req_vld = 0; t1_req_state = 0; t1_req_wait = 0;
        irq = 0; pkg_wake = 0; mon_hit = 0;
    endtask

    function automatic logic [2:0] lo(input logic [2:0] a, input logic [2:0] b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        logic [2:0] p0, p1;
        repeat (3) @(negedge clk);
        check(11, "t0 in reset", t0_state, 3'd0);   // R11
        check(11, "t1 in reset", t1_state, 3'd0);
        check(11, "core in reset", core_state, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        p0 = 3'd0; p1 = 3'd0;
        for (int i = 0; i < NV; i++) begin
            t0_req_vld = VEC[i].v0; t0_req_state = VEC[i].s0; t0_req_wait = VEC[i].w0;
            t1_req_vld = VEC[i].v1; t1_req_state = VEC[i].s1; t1_req_wait = VEC[i].w1;
            irq = VEC[i].ir; pkg_wake = VEC[i].pk; mon_hit = VEC[i].mh;
            @(negedge clk);
            clear_in();
            check(int'(VEC[i].rq), "t0 state", t0_state, VEC[i].e0);
            check(int'(VEC[i].rq), "t1 state", t1_state, VEC[i].e1);
            check(2, "core lags lowest", core_state, lo(p0, p1)); // R2
            p0 = VEC[i].e0; p1 = VEC[i].e1;
        end
        @(negedge clk);
        check(2, "core settles", core_state, lo(p0, p1)); // R2

        // directed: core lag of exactly one cycle (R2)
        t0_req_vld = 1; t0_req_state = 3'd2; t1_req_vld = 1; t1_req_state = 3'd1;
        @(negedge clk);
        clear_in();
        check(2, "core before lag", core_state, 3'd0);
        @(negedge clk);
        check(2, "core after lag", core_state, 3'd1);

        // directed: reset mid-run (R11)
        rst_n = 1'b0;
        @(negedge clk);
        check(11, "t0 after reset", t0_state, 3'd0);
        check(11, "t1 after reset", t1_state, 3'd0);
        check(11, "core after reset", core_state, 3'd0);
        rst_n = 1'b1;

        // directed: hit does not wake a thread without the wait flag (R8)
        @(negedge clk);
        t1_req_vld = 1; t1_req_state = 3'd2; t1_req_wait = 0;
        @(negedge clk);
        clear_in();
        mon_hit = 1;
        @(negedge clk);
        clear_in();
        check(8, "no-wait thread stays", t1_state, 3'd2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule